// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Front End

This block sits in front of a small synchronous memory and accepts one command on every enabled clock edge. Reads and writes may follow one another in any order with no idle cycle between them. Read data flows straight out of the array during the cycle after the command edge, with no output register. Write data is taken on the enabled edge after the write command, so the shared data path never has to turn around. Each command edge either loads a new address or continues the previous operation as a four-beat burst. The burst order is either linear or interleaved, chosen by a mode pin.

The read bus is returned as a data vector plus a separate drive-enable output, and the enclosing pad ring builds the tri-state from these. The output enable input acts without the clock and is overridden whenever the current cycle is not a read. A clock-enable input stalls the whole pipeline. A sleep input shuts off command acceptance, and commands stay blocked for two edges after sleep is released.

Top module: `flowthru_sram`

## Requirements
- R1: A load cycle (`adv`=0) is a deselect when `sel1_n`=1, `sel2`=0 or `sel3_n`=1. After it, `rdata_oe` is 0.
- R2: A cycle with `adv`=1 continues the previous operation type (idle, read or write) at the next burst address. Chip selects and `we_n` are ignored on such a cycle. A continued write samples `bw_n` again.
- R3: An edge with `cke_n`=1 is ignored when no sleep is in force. No state changes, no write is committed, and the read output stays the same.
- R4: After a write command, `rdata_oe` is 0 whatever the value of `oe_n`, including when only some bytes are selected.
- R5: A write cycle with `bw_n`=4'b1111 changes no memory location, and the bus stays undriven.
- R6: `rdata_oe` follows `oe_n` combinationally during a read cycle, with no clock edge needed.
- R7: After reset the block is deselected and `rdata_oe` is 0, even with `oe_n`=0.
- R8: A read with `oe_n`=1 is a dummy read and leaves `rdata_oe` at 0.
- R9: An edge where `sleep`=1 accepts no command and leaves the block idle. The first two edges after `sleep` returns to 0 are also ignored, and the third accepts a command.
- R10: Write data is taken on the next enabled edge after the write command. Only lanes whose `bw_n` bit is 0 are updated, with bit i covering `wdata[8i+7:8i]`.
- R11: A read loaded directly after a write to the same address returns the newly written data.
- R12: Burst beat k (k=0..3) from load address A uses low address bits `(A[1:0]+k) mod 4` when `seq_linear`=1, and `A[1:0] XOR k` when `seq_linear`=0. The upper address bits stay fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | DW/8 | Byte lane write selects, active low |
| cke_n | input | 1 | Clock enable, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep request |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Load address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the window around sleep. It needs a pending write whose data phase lands on a sleep edge, followed by the two blocked recovery edges, and only then an accepted read. A second hard case is a stalled edge placed between a write command and its data phase. Directed sequences build both cases explicitly. Randomised stimulus then mixes sleep pulses, stalls, continue beats and aborted lanes against a bench model, which catches any mismatch in when a write lands.

// File: rtl/flowthru_sram.sv
module flowthru_sram #(
  parameter int DW = 32,
  parameter int DEPTH = 64,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          adv,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          cke_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic          seq_linear,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  op_e           op_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [NB-1:0] bw_q;
  logic [1:0]    wake_q;
  logic [DW-1:0] mem [DEPTH];

  logic          blocked, step, desel;
  logic [1:0]    lo;
  logic [AW-1:0] ea;

  assign blocked = sleep | (wake_q != 2'd0);
  assign step    = ~cke_n | blocked;
  assign desel   = sel1_n | ~sel2 | sel3_n;
  assign lo      = seq_linear ? base_q[1:0] + cnt_q : base_q[1:0] ^ cnt_q;
  assign ea      = {base_q[AW-1:2], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 2'd0;
    else if (sleep) wake_q <= 2'd2;
    else if (wake_q != 2'd0) wake_q <= wake_q - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      bw_q   <= '1;
    end else if (step) begin
      if (blocked) begin
        op_q <= OP_IDLE;
      end else if (adv) begin
        if (op_q != OP_IDLE) cnt_q <= cnt_q + 2'd1;
        if (op_q == OP_WR) bw_q <= bw_n;
      end else if (desel) begin
        op_q <= OP_IDLE;
      end else begin
        op_q   <= we_n ? OP_RD : OP_WR;
        base_q <= addr;
        cnt_q  <= 2'd0;
        bw_q   <= bw_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step && op_q == OP_WR)
      for (int i = 0; i < NB; i++)
        if (!bw_q[i]) mem[ea][8*i +: 8] <= wdata[8*i +: 8];
  end

  assign rdata_oe = (op_q == OP_RD) & ~oe_n;
  assign rdata    = rdata_oe ? mem[ea] : '0;
endmodule

module flowthru_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel1_n,
  input logic       sel2,
  input logic       sel3_n,
  input logic       adv,
  input logic       we_n,
  input logic       cke_n,
  input logic       oe_n,
  input logic       sleep,
  input logic       rdata_oe,
  input logic [1:0] op_q,
  input logic [1:0] cnt_q,
  input logic [1:0] wake_q,
  input logic [5:0] base_lo
);
  logic live;
  assign live = ~cke_n & ~sleep & (wake_q == 2'd0);

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    live && !adv && (sel1_n || !sel2 || sel3_n) |=> !rdata_oe); // R1
  AST_CONT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    live && adv |=> op_q == $past(op_q) && (op_q == 2'd0 || cnt_q == $past(cnt_q) + 2'd1)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n && !sleep && wake_q == 2'd0 |=> $stable(op_q) && $stable(cnt_q) && $stable(base_lo)); // R3
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    live && !adv && !sel1_n && sel2 && !sel3_n && !we_n |=> !rdata_oe); // R4
  AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe); // R8
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdata_oe && wake_q == 2'd2); // R9
  AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> wake_q == 2'd2); // R9
endmodule

bind flowthru_sram flowthru_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
  .adv(adv), .we_n(we_n), .cke_n(cke_n), .oe_n(oe_n), .sleep(sleep),
  .rdata_oe(rdata_oe), .op_q(op_q), .cnt_q(cnt_q), .wake_q(wake_q),
  .base_lo(base_q[5:0])
);

// File: tb/flowthru_sram_tb_top.sv
`timescale 1ns/1ps
module flowthru_sram_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0, adv = 1'b0, we_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic cke_n = 1'b0, oe_n = 1'b0, sleep = 1'b0, seq_linear = 1'b1;
  logic [5:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] mem_m [DEPTH];
  logic [1:0] m_op = 2'd0, m_cnt = 2'd0, m_wake = 2'd0;
  logic [5:0] m_base = '0;
  logic [NB-1:0] m_bw = '1;

  always #10 clk = ~clk;

  flowthru_sram dut_i (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .cke_n(cke_n), .oe_n(oe_n),
    .sleep(sleep), .seq_linear(seq_linear), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [5:0] m_ea();
    logic [1:0] lo;
    lo = seq_linear ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
    return {m_base[5:2], lo};
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdata_oe actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(input string tag);
    logic exp_oe;
    exp_oe = (m_op == 2'd1) && !oe_n;
    chk_bit(rdata_oe, exp_oe, tag);
    if (exp_oe) begin
      checks++;
      if (rdata !== mem_m[m_ea()]) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, rdata, mem_m[m_ea()], $time);
      end
    end
  endtask

  task automatic model_edge();
    logic blk, stp;
    logic [5:0] ea;
    blk = sleep || (m_wake != 2'd0);
    stp = !cke_n || blk;
    ea = m_ea();
    if (sleep) m_wake = 2'd2;
    else if (m_wake != 2'd0) m_wake = m_wake - 2'd1;
    if (stp) begin
      if (m_op == 2'd2)
        for (int l = 0; l < NB; l++)
          if (!m_bw[l]) mem_m[ea][8*l +: 8] = wdata[8*l +: 8];
      if (blk) m_op = 2'd0;
      else if (adv) begin
        if (m_op != 2'd0) begin
          m_cnt = m_cnt + 2'd1;
          if (m_op == 2'd2) m_bw = bw_n;
        end
      end else if (sel1_n || !sel2 || sel3_n) m_op = 2'd0;
      else begin
        m_base = addr; m_cnt = 2'd0; m_bw = bw_n;
        m_op = we_n ? 2'd1 : 2'd2;
      end
    end
  endtask

  task automatic cyc(input logic s1n, input logic s2, input logic s3n, input logic a,
                     input logic wen, input logic [NB-1:0] bwn, input logic cken,
                     input logic oen, input logic slp, input logic [5:0] ad, input string tag);
    @(negedge clk);
    sel1_n = s1n; sel2 = s2; sel3_n = s3n; adv = a; we_n = wen; bw_n = bwn;
    cke_n = cken; oe_n = oen; sleep = slp; addr = ad; wdata = $urandom;
    @(posedge clk);
    model_edge();
    #2 check_out(tag);
  endtask

  task automatic rd(input logic [5:0] ad, input string tag);
    cyc(0, 1, 0, 0, 1, '1, 0, 0, 0, ad, tag);
  endtask
  task automatic wr(input logic [5:0] ad, input logic [NB-1:0] bwn, input string tag);
    cyc(0, 1, 0, 0, 0, bwn, 0, 0, 0, ad, tag);
  endtask
  task automatic cont(input logic [NB-1:0] bwn, input string tag);
    cyc(1, 0, 1, 1, 1, bwn, 0, 0, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1, 1, 0, 0, 1, '1, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk_bit(rdata_oe, 1'b0, "R7");
    rst_n = 1'b1;
    #2 chk_bit(rdata_oe, 1'b0, "R7");

    for (int i = 0; i < DEPTH; i++) wr(6'(i), '0, "R10");
    idle("R10");

    wr(6'd5, '0, "R4");
    rd(6'd5, "R11");
    wr(6'd7, 4'b1010, "R10");
    rd(6'd7, "R10");
    wr(6'd9, 4'b1111, "R5");
    rd(6'd9, "R5");
    cyc(0, 1, 0, 0, 0, '0, 0, 1, 0, 6'd11, "R4");
    cyc(0, 1, 0, 0, 0, 4'b0111, 0, 0, 0, 6'd12, "R4");
    cyc(0, 1, 0, 0, 1, '1, 0, 1, 0, 6'd12, "R8");

    rd(6'd1, "R1");
    cyc(1, 1, 0, 0, 1, '1, 0, 0, 0, 6'd1, "R1");
    rd(6'd2, "R1");
    cyc(0, 0, 0, 0, 1, '1, 0, 0, 0, 6'd2, "R1");
    rd(6'd3, "R1");
    cyc(0, 1, 1, 0, 1, '1, 0, 0, 0, 6'd3, "R1");
    cyc(0, 1, 0, 1, 0, '0, 0, 0, 0, 6'd3, "R2");

    seq_linear = 1'b1;
    rd(6'd13, "R12");
    repeat (3) cont('1, "R12");
    seq_linear = 1'b0;
    rd(6'd22, "R12");
    repeat (3) cont('1, "R12");
    seq_linear = 1'b1;
    wr(6'd40, '0, "R2");
    cont(4'b1100, "R2");
    cont(4'b1111, "R2");
    cont('0, "R2");
    rd(6'd40, "R2");
    repeat (3) cont('1, "R2");

    rd(6'd30, "R3");
    cyc(0, 1, 0, 0, 0, '0, 1, 0, 0, 6'd31, "R3");
    wr(6'd31, '0, "R3");
    cyc(0, 1, 0, 0, 1, '1, 1, 0, 0, 6'd32, "R3");
    rd(6'd31, "R3");

    rd(6'd20, "R6");
    #1 oe_n = 1'b1;
    #1 chk_bit(rdata_oe, 1'b0, "R6");
    oe_n = 1'b0;
    #1 chk_bit(rdata_oe, 1'b1, "R6");

    wr(6'd50, '0, "R9");
    cyc(0, 1, 0, 0, 1, '1, 0, 0, 1, 6'd50, "R9");
    cyc(0, 1, 0, 0, 1, '1, 0, 0, 1, 6'd50, "R9");
    rd(6'd50, "R9");
    rd(6'd50, "R9");
    rd(6'd50, "R9");
    rd(6'd51, "R9");

    for (int n = 0; n < 1500; n++) begin
      logic ds;
      ds = ($urandom_range(5) == 0);
      cyc(ds && $urandom_range(1) == 0, !(ds && $urandom_range(1) == 0), 1'b0,
          $urandom_range(2) == 0, $urandom_range(1) == 0,
          ($urandom_range(5) == 0) ? 4'hF : 4'($urandom),
          $urandom_range(7) == 0, $urandom_range(4) == 0,
          $urandom_range(39) == 0, 6'($urandom_range(63)), "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule